// File: doc/BRIEF.md
# Outbound Address Window Translator

This block maps addresses issued on the CPU side into addresses on an external bus through a single programmable outbound memory window. Software sets the window through a small write/read register port. The CPU-side start and end of the window are packed at 1 MiB granularity. One combined word carries address bits [31:20] of both the start and the end, and two byte-wide registers carry bits [39:32] of the start and the end. A 64-bit bus-side base is written as two 32-bit halves.

For every 40-bit request address, the block reports at once whether the address lies inside the window. On a hit it outputs the rebased bus address, which is the bus base plus the distance of the request from the window start. On a miss the hit flag is low and the output address is zero. After reset every register is clear, and the window is disabled until software programs it.

Top module: `obwin_xlate`

## Requirements
- R1: After reset, all five window registers read back as zero, `hit` is low and `busAddr` is zero.
- R2: Register index map: 0 is the packed CPU window word, 1 is the start-high byte, 2 is the end-high byte, 3 is the bus base bits [31:0], and 4 is the bus base bits [63:32]. A write becomes visible on `rdData` and in translation from the cycle after the clock edge that captures it, and not before.
- R3: Bits that a register does not implement read as zero. The packed word keeps only bits [31:20] and [15:4]. The two high-byte registers keep only bits [7:0].
- R4: Writes to indices 5 to 7 change no register, and reads of those indices return zero.
- R5: The window start is formed from start-high[7:0] as bits [39:32], packed-word bits [15:4] as bits [31:20], and zeros in bits [19:0].
- R6: The window end is formed from end-high[7:0] as bits [39:32], packed-word bits [31:20] as bits [31:20], and ones in bits [19:0].
- R7: `hit` is high exactly when the window is enabled and start <= `reqAddr` <= end. Both ends are inclusive.
- R8: On a hit, `busAddr` = bus base + (`reqAddr` − start), taken modulo 2^64.
- R9: On a miss, `busAddr` is zero.
- R10: When the packed word and both high bytes are all zero, the window is disabled and never hits, whatever the bus base holds.
- R11: When the end lies below the start, the window never hits.
- R12: `hit` and `busAddr` follow `reqAddr` in the same cycle, with no register between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Register index for writes |
| wrData | input | 32 | Write data |
| rdAddr | input | 3 | Register index for readback |
| rdData | output | 32 | Readback data (combinational) |
| reqAddr | input | 40 | CPU-side request address |
| hit | output | 1 | Request falls in the window |
| busAddr | output | 64 | Translated bus address, zero on miss |

## Verification
Some properties are checked on every cycle. A miss always gives a zero output. A disabled or inverted window never hits. A hit always has a request at or above the window start. At most one register strobe fires per write, and each strobed register takes the written value on the next edge while every other register holds. The bench scenarios are the only place where the decode itself is shown. They cover the exact inclusive edges of the range, the upper-byte comparison, the 64-bit wraparound of the rebased address, the masking of unimplemented bits and the one-cycle write latency, since each of these depends on concrete values rather than a relation that holds in every cycle.

// File: rtl/obwin_pkg.sv
package obwin_pkg;
  localparam int REG_AW = 3;

  typedef enum logic [REG_AW-1:0] {
    REG_CPU_WIN  = 3'd0,
    REG_START_HI = 3'd1,
    REG_END_HI   = 3'd2,
    REG_BUS_LO   = 3'd3,
    REG_BUS_HI   = 3'd4
  } regIdx_e;

  typedef struct packed {
    logic ldCpuWin;
    logic ldStartHi;
    logic ldEndHi;
    logic ldBusLo;
    logic ldBusHi;
  } winStrobe_t;
endpackage

// File: rtl/obwin_ctrl.sv
module obwin_ctrl
  import obwin_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [REG_AW-1:0] wrAddr,
  output winStrobe_t        strobes
);
  always_comb begin
    strobes = '0;
    if (wrEn) begin
      case (wrAddr)
        REG_CPU_WIN:  strobes.ldCpuWin  = 1'b1;
        REG_START_HI: strobes.ldStartHi = 1'b1;
        REG_END_HI:   strobes.ldEndHi   = 1'b1;
        REG_BUS_LO:   strobes.ldBusLo   = 1'b1;
        REG_BUS_HI:   strobes.ldBusHi   = 1'b1;
        default:      strobes = '0;
      endcase
    end
  end

  // R2: a single write loads at most one register
  a_r2_one_strobe: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobes));

  // R4: writes to unmapped indices load nothing
  a_r4_unmapped_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr > 3'd4) |-> (strobes == '0));
endmodule

// File: rtl/obwin_dpath.sv
module obwin_dpath
  import obwin_pkg::*;
#(
  parameter int CPU_AW  = 40,
  parameter int BUS_AW  = 64,
  parameter int WORD_W  = 32,
  parameter int GRAN    = 20,
  parameter int BASE_LSB = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  winStrobe_t        strobes,
  input  logic [WORD_W-1:0] wrData,
  input  logic [REG_AW-1:0] rdAddr,
  output logic [WORD_W-1:0] rdData,
  input  logic [CPU_AW-1:0] reqAddr,
  output logic              hit,
  output logic [BUS_AW-1:0] busAddr
);
  localparam int FIELD_W = WORD_W - GRAN;
  localparam int HI_W    = CPU_AW - WORD_W;
  localparam int GAP_W   = GRAN - BASE_LSB - FIELD_W;
  localparam int BHI_W   = BUS_AW - WORD_W;
  localparam int EXT_W   = BUS_AW - CPU_AW;

  logic [FIELD_W-1:0] baseField, limField;
  logic [HI_W-1:0]    startHi, endHi;
  logic [WORD_W-1:0]  busLo;
  logic [BHI_W-1:0]   busHi;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseField <= '0;
      limField  <= '0;
      startHi   <= '0;
      endHi     <= '0;
      busLo     <= '0;
      busHi     <= '0;
    end else begin
      if (strobes.ldCpuWin) begin
        baseField <= wrData[BASE_LSB +: FIELD_W];
        limField  <= wrData[GRAN +: FIELD_W];
      end
      if (strobes.ldStartHi) startHi <= wrData[HI_W-1:0];
      if (strobes.ldEndHi)   endHi   <= wrData[HI_W-1:0];
      if (strobes.ldBusLo)   busLo   <= wrData;
      if (strobes.ldBusHi)   busHi   <= wrData[BHI_W-1:0];
    end
  end

  always_comb begin
    case (rdAddr)
      REG_CPU_WIN:  rdData = {limField, {GAP_W{1'b0}}, baseField, {BASE_LSB{1'b0}}};
      REG_START_HI: rdData = {{(WORD_W-HI_W){1'b0}}, startHi};
      REG_END_HI:   rdData = {{(WORD_W-HI_W){1'b0}}, endHi};
      REG_BUS_LO:   rdData = busLo;
      REG_BUS_HI:   rdData = busHi[WORD_W-1:0];
      default:      rdData = '0;
    endcase
  end

  logic [CPU_AW-1:0] cpuBase, cpuLimit, offset;
  logic [BUS_AW-1:0] busBase;
  logic              winEnable, inRange;

  assign cpuBase   = {startHi, baseField, {GRAN{1'b0}}};
  assign cpuLimit  = {endHi, limField, {GRAN{1'b1}}};
  assign busBase   = {busHi, busLo};
  assign winEnable = |{startHi, endHi, baseField, limField};
  assign inRange   = (reqAddr >= cpuBase) && (reqAddr <= cpuLimit);
  assign hit       = winEnable && inRange;
  assign offset    = reqAddr - cpuBase;
  assign busAddr   = hit ? (busBase + {{EXT_W{1'b0}}, offset}) : '0;

  // R9: a miss never leaks an address
  a_r9_miss_zero: assert property (@(posedge clk) disable iff (!rstN)
    !hit |-> (busAddr == '0));

  // R10: cleared window fields mean no hit
  a_r10_disabled: assert property (@(posedge clk) disable iff (!rstN)
    (startHi == '0 && endHi == '0 && baseField == '0 && limField == '0) |-> !hit);

  // R11: inverted range never hits
  a_r11_inverted: assert property (@(posedge clk) disable iff (!rstN)
    (cpuLimit < cpuBase) |-> !hit);

  // R7: a hit lies at or above the window start
  a_r7_above_start: assert property (@(posedge clk) disable iff (!rstN)
    hit |-> (reqAddr >= cpuBase));

  // R2: a strobed bus-base word holds the written data one edge later
  a_r2_bus_lo_load: assert property (@(posedge clk) disable iff (!rstN)
    strobes.ldBusLo |=> (busLo == $past(wrData)));

  // R2: with no strobe, window state holds
  a_r2_hold: assert property (@(posedge clk) disable iff (!rstN)
    (strobes == '0) |=> ($stable(busLo) && $stable(busHi) && $stable(startHi) &&
                         $stable(endHi) && $stable(baseField) && $stable(limField)));
endmodule

// File: rtl/obwin_xlate.sv
module obwin_xlate
  import obwin_pkg::*;
#(
  parameter int CPU_AW = 40,
  parameter int BUS_AW = 64,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [2:0]        wrAddr,
  input  logic [WORD_W-1:0] wrData,
  input  logic [2:0]        rdAddr,
  output logic [WORD_W-1:0] rdData,
  input  logic [CPU_AW-1:0] reqAddr,
  output logic              hit,
  output logic [BUS_AW-1:0] busAddr
);
  winStrobe_t strobes;

  obwin_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .wrEn    (wrEn),
    .wrAddr  (wrAddr),
    .strobes (strobes)
  );

  obwin_dpath #(
    .CPU_AW (CPU_AW),
    .BUS_AW (BUS_AW),
    .WORD_W (WORD_W)
  ) u_dpath (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .wrData  (wrData),
    .rdAddr  (rdAddr),
    .rdData  (rdData),
    .reqAddr (reqAddr),
    .hit     (hit),
    .busAddr (busAddr)
  );
endmodule

// File: tb/sim_obwin_xlate.sv
`timescale 1ns/1ps
module sim_obwin_xlate;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  wrAddr = '0;
  logic [31:0] wrData = '0;
  logic [2:0]  rdAddr = '0;
  logic [31:0] rdData;
  logic [39:0] reqAddr = '0;
  logic        hit;
  logic [63:0] busAddr;

  int nChecks = 0;
  int nFails  = 0;

  always #2 clk = ~clk;

  obwin_xlate u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .reqAddr(reqAddr), .hit(hit), .busAddr(busAddr)
  );

  typedef struct packed {
    logic [31:0] cpuWin;
    logic [7:0]  sHi;
    logic [7:0]  eHi;
    logic [31:0] bLo;
    logic [31:0] bHi;
    logic [39:0] req;
    logic        expHit;
    logic [63:0] expBus;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    // window 0x00_4000_0000..0x00_4FFF_FFFF -> bus 0x6_0000_0000
    '{32'h4FF0_4000, 8'h00, 8'h00, 32'h0, 32'h6, 40'h00_4000_0000, 1'b1, 64'h0000_0006_0000_0000},
    '{32'h4FF0_4000, 8'h00, 8'h00, 32'h0, 32'h6, 40'h00_4FFF_FFFF, 1'b1, 64'h0000_0006_0FFF_FFFF},
    '{32'h4FF0_4000, 8'h00, 8'h00, 32'h0, 32'h6, 40'h00_3FFF_FFFF, 1'b0, 64'h0},
    '{32'h4FF0_4000, 8'h00, 8'h00, 32'h0, 32'h6, 40'h00_5000_0000, 1'b0, 64'h0},
    '{32'h4FF0_4000, 8'h00, 8'h00, 32'h0, 32'h6, 40'h00_4123_4567, 1'b1, 64'h0000_0006_0123_4567},
    // window 0x12_0010_0000..0x13_000F_FFFF -> bus 0xFFFF_FFFF_FFF0_0000
    '{32'h0000_0010, 8'h12, 8'h13, 32'hFFF0_0000, 32'hFFFF_FFFF, 40'h12_0010_0000, 1'b1, 64'hFFFF_FFFF_FFF0_0000},
    '{32'h0000_0010, 8'h12, 8'h13, 32'hFFF0_0000, 32'hFFFF_FFFF, 40'h12_0020_0005, 1'b1, 64'h0000_0000_0000_0005},
    '{32'h0000_0010, 8'h12, 8'h13, 32'hFFF0_0000, 32'hFFFF_FFFF, 40'h13_000F_FFFF, 1'b1, 64'h0000_0000_FFEF_FFFF},
    '{32'h0000_0010, 8'h12, 8'h13, 32'hFFF0_0000, 32'hFFFF_FFFF, 40'h13_0010_0000, 1'b0, 64'h0},
    '{32'h0000_0010, 8'h12, 8'h13, 32'hFFF0_0000, 32'hFFFF_FFFF, 40'h12_000F_FFFF, 1'b0, 64'h0},
    '{32'h0000_0010, 8'h12, 8'h13, 32'hFFF0_0000, 32'hFFFF_FFFF, 40'h02_0010_0000, 1'b0, 64'h0},
    // inverted window: start 0x8000_0000, end 0x100F_FFFF
    '{32'h1000_8000, 8'h00, 8'h00, 32'h0, 32'h0, 40'h00_8000_0000, 1'b0, 64'h0},
    '{32'h1000_8000, 8'h00, 8'h00, 32'h0, 32'h0, 40'h00_1000_0000, 1'b0, 64'h0},
    // single 1 MiB window at 0x0010_0000 -> bus 0x100
    '{32'h0010_0010, 8'h00, 8'h00, 32'h100, 32'h0, 40'h00_0010_0000, 1'b1, 64'h100},
    '{32'h0010_0010, 8'h00, 8'h00, 32'h100, 32'h0, 40'h00_001F_FFFF, 1'b1, 64'h0010_00FF},
    '{32'h0010_0010, 8'h00, 8'h00, 32'h100, 32'h0, 40'h00_0020_0000, 1'b0, 64'h0}
  };

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wrReg(input logic [2:0] idx, input logic [31:0] val);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = idx; wrData = val;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rdCheck(input string tag, input logic [2:0] idx, input logic [31:0] exp);
    rdAddr = idx;
    #0.5;
    check(tag, {32'h0, rdData}, {32'h0, exp});
  endtask

  initial begin
    #(4 * 200000);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state
    for (int k = 0; k < 5; k++) rdCheck("R1 reset readback", 3'(k), 32'h0);
    reqAddr = 40'h0; #0.5;
    check("R1 reset hit", {63'h0, hit}, 64'h0);
    check("R1 reset busAddr", busAddr, 64'h0);

    // R10: all-zero window disabled even with bus base set and request in the implied MiB
    wrReg(3'd3, 32'hDEAD_0000);
    reqAddr = 40'h00_000F_FFFF; #0.5;
    check("R10 disabled hit", {63'h0, hit}, 64'h0);
    check("R10 disabled busAddr", busAddr, 64'h0);

    // Vector table: R5 R6 R7 R8 R9 R11
    for (int i = 0; i < NV; i++) begin
      wrReg(3'd0, VECS[i].cpuWin);
      wrReg(3'd1, {24'h0, VECS[i].sHi});
      wrReg(3'd2, {24'h0, VECS[i].eHi});
      wrReg(3'd3, VECS[i].bLo);
      wrReg(3'd4, VECS[i].bHi);
      reqAddr = VECS[i].req;
      #0.5;
      check("R7 R11 hit vector", {63'h0, hit}, {63'h0, VECS[i].expHit});
      check("R8 R9 busAddr vector", busAddr, VECS[i].expBus);
    end

    // R12: output follows request in the same cycle (no edge in between)
    @(negedge clk);
    reqAddr = 40'h00_0010_0004; #0.5;
    check("R12 same-cycle hit", {63'h0, hit}, 64'h1);
    check("R12 same-cycle busAddr", busAddr, 64'h104);

    // R3: unimplemented bits read zero
    wrReg(3'd0, 32'hFFFF_FFFF);
    rdCheck("R3 packed word mask", 3'd0, 32'hFFF0_FFF0);
    wrReg(3'd1, 32'hABCD_EF12);
    rdCheck("R3 start-high mask", 3'd1, 32'h0000_0012);
    wrReg(3'd2, 32'h1234_5678);
    rdCheck("R3 end-high mask", 3'd2, 32'h0000_0078);

    // R4: unmapped writes touch nothing; unmapped reads are zero
    wrReg(3'd3, 32'h1111_2222);
    wrReg(3'd4, 32'h3333_4444);
    wrReg(3'd5, 32'hFFFF_FFFF);
    wrReg(3'd7, 32'hFFFF_FFFF);
    rdCheck("R4 unmapped read 5", 3'd5, 32'h0);
    rdCheck("R4 unmapped read 7", 3'd7, 32'h0);
    rdCheck("R4 cpu word intact", 3'd0, 32'hFFF0_FFF0);
    rdCheck("R4 start-high intact", 3'd1, 32'h12);
    rdCheck("R4 end-high intact", 3'd2, 32'h78);
    rdCheck("R4 bus lo intact", 3'd3, 32'h1111_2222);
    rdCheck("R4 bus hi intact", 3'd4, 32'h3333_4444);

    // R2: write invisible before the capturing edge, visible after
    @(negedge clk);
    wrEn = 1'b1; wrAddr = 3'd3; wrData = 32'hCAFE_F00D;
    rdCheck("R2 before edge", 3'd3, 32'h1111_2222);
    @(negedge clk);
    wrEn = 1'b0;
    rdCheck("R2 after edge", 3'd3, 32'hCAFE_F00D);

    // R1: asynchronous reset clears everything again
    rstN = 1'b0; #0.5;
    rdCheck("R1 re-reset bus lo", 3'd3, 32'h0);
    rdCheck("R1 re-reset cpu word", 3'd0, 32'h0);
    @(negedge clk);
    rstN = 1'b1;

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule